// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

The block holds one free-running main counter and a set of comparator channels that all watch it. Software programs a channel with a compare value. When the shared counter reaches that value the channel records an event, either as a status bit that stays set until software acknowledges it or as a single-cycle pulse. A channel may fire once, or it may re-arm itself by adding a programmed period to its compare value after every match. Channel activity never writes the main counter, so every channel sees the same timebase.

Software reaches the block through a plain 32-bit register port. A read returns data one clock after the request. Registers that hold 64 bits are split into a low word at the base offset and a high word four bytes above it. Global registers: capability (0x000 low, 0x004 high), run control (0x010), event status (0x020) and main counter (0x0F0/0x0F4). Channel n occupies 0x100 + 32*n: configuration (low word +0x00, route capability +0x04) and compare (+0x08 low, +0x0C high).

Configuration bits: 1 = level mode (0 = pulse mode), 2 = interrupt enable, 3 = periodic select, 4 = periodic capable (read-only), 6 = first-value arm, 8 = 32-bit compare, 13:9 = route select.

Top module: `evt_timer`

## Requirements
- R1: After reset the capability low word reads channels minus one in bits 4:0 and a 1 in bit 8 for a 64-bit counter. The capability high word reads the tick period in femtoseconds. Run control, event status and every interrupt line read 0.
- R2: While run control bit 0 is set, the main counter increments once per clock. Writes to its low or high word are ignored while it runs. While bit 0 is clear, the counter holds and takes those writes.
- R3: In level mode, a channel's bit n in event status goes to 1 on the clock after a clock in which the counter ran and equalled its compare value. This happens whether or not its interrupt is enabled.
- R4: A level-mode status bit stays set until a status write carries a 1 at bit n. Writing 0 there has no effect. The level interrupt line follows the status bit while its enable bit is set.
- R5: A channel whose interrupt enable bit is clear never drives its interrupt line.
- R6: In pulse mode, a match drives the channel's interrupt line for exactly one clock, on the clock after the match, and the status bit stays 0.
- R7: With periodic mode and the arm bit set, compare writes load the first absolute expiry. The arm bit clears after the high-word write, or after the low-word write when 32-bit compare is set. Later compare writes set the period.
- R8: After each match in periodic mode, the compare value, read back at +0x08, advances by the period.
- R9: On a channel without periodic capability, the periodic select and arm bits read 0 after any configuration write, and the channel keeps one-shot behaviour.
- R10: With 32-bit compare set, a channel matches on the low 32 bits of the counter alone.
- R11: A route-select value is accepted only if its bit is set in the channel's route capability word (+0x04). Otherwise the previous route is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read request |
| irq_o | output | NCH | One interrupt line per channel |

## Verification
The bench sets the counter to a known value while it is stopped. From that point it knows the counter value on every clock, and it checks each interrupt line clock by clock around the expected match. An off-by-one in the match-to-line latency, or a pulse longer than one clock, shows up directly. The periodic run reads the compare value back after four matches, which exposes a design that loads the period into the first expiry or never clears the arm bit. A counter written while it runs, a 32-bit compare that still checks the high word, and a periodic bit accepted on a channel without the capability each produce a wrong readback or a missing or extra interrupt.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 12;
    localparam int CH_SLOTS = 8;

    localparam logic [ADDR_W-1:0] A_CAP_LO = 12'h000;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 12'h004;
    localparam logic [ADDR_W-1:0] A_RUN    = 12'h010;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 12'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h0F4;

    localparam logic [3:0] CH_PAGE = 4'h1;

    localparam logic [4:0] O_CFG_LO = 5'h00;
    localparam logic [4:0] O_CFG_HI = 5'h04;
    localparam logic [4:0] O_CMP_LO = 5'h08;
    localparam logic [4:0] O_CMP_HI = 5'h0C;

    localparam int B_LVL   = 1;
    localparam int B_IE    = 2;
    localparam int B_PER   = 3;
    localparam int B_PCAP  = 4;
    localparam int B_ARM   = 6;
    localparam int B_F32   = 8;
    localparam int B_RT_LO = 9;
    localparam int RT_W    = 5;

    typedef struct packed {
        logic [RT_W-1:0] route;
        logic            f32;
        logic            arm;
        logic            per;
        logic            ie;
        logic            lvl;
    } ch_cfg_t;

    function automatic logic [63:0] put_half(input logic [63:0] v, input logic hi,
                                             input logic [BUS_W-1:0] d);
        logic [63:0] r;
        r = v;
        if (hi) r[63:32] = d;
        else    r[31:0]  = d;
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_word(input ch_cfg_t c, input logic pcap);
        logic [BUS_W-1:0] w;
        w = '0;
        w[B_LVL]  = c.lvl;
        w[B_IE]   = c.ie;
        w[B_PER]  = c.per;
        w[B_PCAP] = pcap;
        w[B_ARM]  = c.arm;
        w[B_F32]  = c.f32;
        w[B_RT_LO +: RT_W] = c.route;
        return w;
    endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             ld_lo_i,
    input  logic             ld_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [63:0]      wide;

    always_comb begin
        wide = 64'(cnt_q);
        if (ld_lo_i) wide = put_half(wide, 1'b0, wdata_i);
        if (ld_hi_i) wide = put_half(wide, 1'b1, wdata_i);
    end

    always_ff @(posedge clk) begin
        if (rst)                     cnt_q <= '0;
        else if (run_i)              cnt_q <= cnt_q + CNT_W'(1);
        else if (ld_lo_i || ld_hi_i) cnt_q <= wide[CNT_W-1:0];
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter int          CNT_W     = 64,
    parameter logic        PER_CAP   = 1'b1,
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0030
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             run_i,
    input  logic             cfg_we_i,
    input  logic             cmp_we_lo_i,
    input  logic             cmp_we_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             sts_clr_i,
    output ch_cfg_t          cfg_o,
    output logic [CNT_W-1:0] acc_o,
    output logic             sts_o,
    output logic             irq_o
);

    ch_cfg_t          cfg_q, cfg_n;
    logic [CNT_W-1:0] acc_q, acc_n, per_q, per_n;
    logic [63:0]      acc_w, per_w;
    logic             sts_q, pulse_q;
    logic             hit, to_acc, arm_done, cmp_we;

    assign hit      = run_i && (cfg_q.f32 ? (cnt_i[31:0] == acc_q[31:0]) : (cnt_i == acc_q));
    assign cmp_we   = cmp_we_lo_i || cmp_we_hi_i;
    assign to_acc   = !cfg_q.per || cfg_q.arm;
    assign arm_done = cmp_we_hi_i || (cmp_we_lo_i && cfg_q.f32);

    always_comb begin
        acc_w = 64'(acc_q);
        per_w = 64'(per_q);
        if (cmp_we) begin
            if (to_acc) acc_w = put_half(acc_w, cmp_we_hi_i, wdata_i);
            else        per_w = put_half(per_w, cmp_we_hi_i, wdata_i);
        end
        acc_n = acc_w[CNT_W-1:0];
        per_n = per_w[CNT_W-1:0];
        if (hit && cfg_q.per && !cmp_we) begin
            if (cfg_q.f32) acc_n[31:0] = acc_q[31:0] + per_q[31:0];
            else           acc_n       = acc_q + per_q;
        end
    end

    always_comb begin
        cfg_n = cfg_q;
        if (cfg_we_i) begin
            cfg_n.lvl = wdata_i[B_LVL];
            cfg_n.ie  = wdata_i[B_IE];
            cfg_n.f32 = wdata_i[B_F32];
            cfg_n.per = wdata_i[B_PER] & PER_CAP;
            cfg_n.arm = wdata_i[B_ARM] & PER_CAP;
            if (ROUTE_CAP[wdata_i[B_RT_LO +: RT_W]])
                cfg_n.route = wdata_i[B_RT_LO +: RT_W];
        end else if (arm_done) begin
            cfg_n.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            acc_q   <= '0;
            per_q   <= '0;
            sts_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cfg_q   <= cfg_n;
            acc_q   <= acc_n;
            per_q   <= per_n;
            sts_q   <= cfg_q.lvl ? ((sts_q && !sts_clr_i) || hit) : 1'b0;
            pulse_q <= hit && cfg_q.ie && !cfg_q.lvl;
        end
    end

    assign cfg_o = cfg_q;
    assign acc_o = acc_q;
    assign sts_o = sts_q;
    assign irq_o = cfg_q.lvl ? (sts_q && cfg_q.ie) : pulse_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NCH          = 3,
    parameter int          CNT_W        = 64,
    parameter logic [31:0] TICK_FS      = 32'd10_000_000,
    parameter logic [7:0]  PER_CAP_MASK = 8'h03,
    parameter logic [31:0] ROUTE_CAP    = 32'h0000_0030
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq_o
);

    localparam logic [BUS_W-1:0] CAP_LO = BUS_W'(NCH - 1) | ((CNT_W == 64) ? 32'h100 : 32'h0);

    logic             is_wr, is_rd, ch_page, run_q;
    logic [2:0]       ch_idx;
    logic [4:0]       ch_off;
    logic [CNT_W-1:0] cnt_q;
    logic [NCH-1:0]   sts_v;
    ch_cfg_t [NCH-1:0] cfg_v;
    logic [CNT_W-1:0] acc_v [NCH];
    logic [BUS_W-1:0] rd_n;
    logic [63:0]      wide_rd;

    assign is_wr   = bus_sel && bus_wr;
    assign is_rd   = bus_sel && !bus_wr;
    assign ch_page = bus_addr[11:8] == CH_PAGE;
    assign ch_idx  = bus_addr[7:5];
    assign ch_off  = bus_addr[4:0];

    always_ff @(posedge clk) begin
        if (rst)                             run_q <= 1'b0;
        else if (is_wr && bus_addr == A_RUN) run_q <= bus_wdata[0];
    end

    evt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_q),
        .ld_lo_i (is_wr && bus_addr == A_CNT_LO),
        .ld_hi_i (is_wr && bus_addr == A_CNT_HI),
        .wdata_i (bus_wdata),
        .cnt_o   (cnt_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel;
        assign sel = ch_page && (ch_idx == 3'(g));
        evt_channel #(
            .CNT_W     (CNT_W),
            .PER_CAP   (PER_CAP_MASK[g]),
            .ROUTE_CAP (ROUTE_CAP)
        ) u_ch (
            .clk         (clk),
            .rst         (rst),
            .cnt_i       (cnt_q),
            .run_i       (run_q),
            .cfg_we_i    (is_wr && sel && ch_off == O_CFG_LO),
            .cmp_we_lo_i (is_wr && sel && ch_off == O_CMP_LO),
            .cmp_we_hi_i (is_wr && sel && ch_off == O_CMP_HI),
            .wdata_i     (bus_wdata),
            .sts_clr_i   (is_wr && bus_addr == A_ISTAT && bus_wdata[g]),
            .cfg_o       (cfg_v[g]),
            .acc_o       (acc_v[g]),
            .sts_o       (sts_v[g]),
            .irq_o       (irq_o[g])
        );
    end

    always_comb begin
        rd_n    = '0;
        wide_rd = 64'(cnt_q);
        case (bus_addr)
            A_CAP_LO: rd_n = CAP_LO;
            A_CAP_HI: rd_n = TICK_FS;
            A_RUN:    rd_n = BUS_W'(run_q);
            A_ISTAT:  rd_n = BUS_W'(sts_v);
            A_CNT_LO: rd_n = wide_rd[31:0];
            A_CNT_HI: rd_n = wide_rd[63:32];
            default:  ;
        endcase
        if (ch_page) begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_idx == 3'(i)) begin
                    wide_rd = 64'(acc_v[i]);
                    case (ch_off)
                        O_CFG_LO: rd_n = cfg_word(cfg_v[i], PER_CAP_MASK[i]);
                        O_CFG_HI: rd_n = ROUTE_CAP;
                        O_CMP_LO: rd_n = wide_rd[31:0];
                        O_CMP_HI: rd_n = wide_rd[63:32];
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (is_rd) bus_rdata <= rd_n;
    end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int         NCH          = 3,
    parameter int         CNT_W        = 64,
    parameter logic [7:0] PER_CAP_MASK = 8'h03
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [NCH-1:0]    irq_o,
    input logic              run_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [NCH-1:0]    sts_v,
    input ch_cfg_t [NCH-1:0] cfg_v
);

    logic cnt_ld, istat_wr;
    assign cnt_ld   = bus_sel && bus_wr && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
    assign istat_wr = bus_sel && bus_wr && (bus_addr == A_ISTAT);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        run_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_ld) |=> $stable(cnt_q));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_sts_src_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(sts_v[i]) |-> $past(run_q));

        p_sts_keep_r4: assert property (@(posedge clk) disable iff (rst)
            (sts_v[i] && cfg_v[i].lvl && !(istat_wr && bus_wdata[i])) |=> sts_v[i]);

        p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
            irq_o[i] |-> (cfg_v[i].ie || $past(cfg_v[i].ie)));

        p_pulse_nosts_r6: assert property (@(posedge clk) disable iff (rst)
            !cfg_v[i].lvl |=> !sts_v[i]);

        p_percap_r9: assert property (@(posedge clk) disable iff (rst)
            !PER_CAP_MASK[i] |-> (!cfg_v[i].per && !cfg_v[i].arm));
    end

endmodule

bind evt_timer evt_timer_chk #(
    .NCH          (NCH),
    .CNT_W        (CNT_W),
    .PER_CAP_MASK (PER_CAP_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .run_q     (run_q),
    .cnt_q     (cnt_q),
    .sts_v     (sts_v),
    .cfg_v     (cfg_v)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;

    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rd_pend = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    evt_timer #(.NCH(NCH)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare each read result against the scoreboard entry
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    function automatic logic [11:0] cha(input int n, input logic [4:0] off);
        return 12'h100 + 12'(n * 32) + 12'(off);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and capability
        rd(12'h000, 32'h0000_0102, "R1 cap low");
        rd(12'h004, 32'd10_000_000, "R1 cap high");
        rd(12'h010, 32'h0, "R1 run ctrl");
        rd(12'h020, 32'h0, "R1 status");
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2: load while stopped, ignore while running
        wr(12'h0F0, 32'd5);
        wr(12'h0F4, 32'd1);
        rd(12'h0F0, 32'd5, "R2 counter low load");
        rd(12'h0F4, 32'd1, "R2 counter high load");
        wr(12'h0F0, 32'd0);
        wr(12'h0F4, 32'd0);
        wr(12'h010, 32'd1);
        wr(12'h0F0, 32'd1000);
        wr(12'h010, 32'd0);
        rd(12'h0F0, 32'd2, "R2 write ignored while running");
        rd(12'h0F4, 32'd0, "R2 counter high after run");

        // R3 R4 R5 R6: one-shot level, level without enable, pulse mode
        wr(12'h0F0, 32'd0);
        wr(cha(0, 5'h00), 32'h6);
        wr(cha(0, 5'h08), 32'd10);
        wr(cha(0, 5'h0C), 32'd0);
        wr(cha(1, 5'h00), 32'h2);
        wr(cha(1, 5'h08), 32'd12);
        wr(cha(1, 5'h0C), 32'd0);
        wr(cha(2, 5'h00), 32'h4);
        wr(cha(2, 5'h08), 32'd20);
        wr(cha(2, 5'h0C), 32'd0);
        wr(12'h010, 32'd1);
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            chk($sformatf("R3 R5 R6 irq at step %0d", k), 32'(irq),
                {29'b0, (k == 21), 1'b0, (k >= 11)});
        end
        rd(12'h020, 32'h3, "R3 status set with and without enable");
        wr(12'h020, 32'h0);
        rd(12'h020, 32'h3, "R4 write of zero keeps status");
        wr(12'h020, 32'h1);
        chk("R4 level line drops after clear", 32'(irq), 32'h0);
        rd(12'h020, 32'h2, "R4 only written bit cleared");

        // R7 R8: periodic on channel 0, pulse mode
        wr(12'h010, 32'd0);
        wr(12'h0F0, 32'd0);
        wr(12'h0F4, 32'd0);
        wr(12'h020, 32'h7);
        wr(cha(0, 5'h00), 32'h4C);
        wr(cha(0, 5'h08), 32'd5);
        wr(cha(0, 5'h0C), 32'd0);
        wr(cha(0, 5'h08), 32'd4);
        wr(cha(0, 5'h0C), 32'd0);
        rd(cha(0, 5'h00), 32'h1C, "R7 arm bit cleared after first value");
        rd(cha(0, 5'h08), 32'd5, "R7 first expiry kept");
        wr(12'h010, 32'd1);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk($sformatf("R7 periodic pulse at step %0d", k), 32'(irq[0]),
                32'((k == 6) || (k == 10) || (k == 14) || (k == 18)));
        end
        wr(12'h010, 32'd0);
        rd(cha(0, 5'h08), 32'd21, "R8 compare advanced by period");

        // R9: no periodic capability on channel 2
        wr(cha(2, 5'h00), 32'h4C);
        rd(cha(2, 5'h00), 32'h04, "R9 periodic and arm ignored");

        // R10: 32-bit compare on channel 1, full compare on channel 0
        wr(12'h0F0, 32'd0);
        wr(12'h0F4, 32'd3);
        wr(12'h020, 32'h7);
        wr(cha(0, 5'h00), 32'h6);
        wr(cha(0, 5'h08), 32'd8);
        wr(cha(0, 5'h0C), 32'd0);
        wr(cha(1, 5'h00), 32'h106);
        wr(cha(1, 5'h08), 32'd8);
        wr(cha(1, 5'h0C), 32'd0);
        wr(12'h010, 32'd1);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk($sformatf("R10 low-word match at step %0d", k), 32'(irq),
                {30'b0, (k >= 9), 1'b0});
        end
        wr(12'h010, 32'd0);
        rd(12'h020, 32'h2, "R10 only low-word channel matched");

        // R11: route select filtered by capability
        rd(cha(1, 5'h04), 32'h30, "R11 route capability");
        wr(cha(1, 5'h00), 32'hA00);
        rd(cha(1, 5'h00), 32'hA10, "R11 capable route accepted");
        wr(cha(1, 5'h00), 32'h600);
        rd(cha(1, 5'h00), 32'hA10, "R11 incapable route rejected");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule